// File: doc/BRIEF.md
# Chained SPI Receive/Forward Node

This block is a serial peripheral node for a chain of identical nodes. All nodes share one active-low select line and one serial clock. The first node's serial input comes from the controller's data-out line. Each node's serial output drives the serial input of the next node, and the last node's output returns to the controller. While the select line is low, every node moves bits through an 8-bit shift register on each serial clock, so a stream of bytes passes down the chain. In a chain of K nodes, the byte sent first ends up in the node farthest from the controller, and node N needs 8*N serial clocks before its byte arrives.

When the select line goes low, each node loads its pending response byte into its shift register, and that byte then travels toward the controller. When the select line returns high, each node keeps whatever its register holds at that moment and pulses a one-cycle valid strobe. The pins are synchronised into the system clock domain, and all edges are detected there. The serial clock must run at no more than one quarter of the system clock rate. Clocking follows mode 0: the node samples on the rising edge of the serial clock and changes its output on the falling edge.

Top module: `chain_spi_node`

## Requirements
- R1: After reset, `sdo_o`, `rx_data_o` and `rx_valid_o` are all 0.
- R2: While `csn_i` is low, each rising `sclk_i` edge shifts `sdi_i` into the register, most significant bit first. After an 8-bit frame, the first bit sent is `rx_data_o[7]` and the last is `rx_data_o[0]`.
- R3: On each low-to-high change of `csn_i`, `rx_data_o` takes the register contents and `rx_valid_o` is high for exactly one system cycle. At all other times `rx_data_o` holds its value.
- R4: On the high-to-low change of `csn_i`, the node captures `resp_i`. `sdo_o` shows `resp_i[7]` before the first rising `sclk_i` edge and then bits 6 down to 0 after successive falling edges. Changes on `resp_i` later in the frame have no effect on that frame.
- R5: After the 8 response bits, `sdo_o` repeats the bits received on `sdi_i`, 8 serial clocks later and in the same order.
- R6: In a chain of 3 nodes with a 24-bit frame, the nearest node holds the last byte sent, the middle node the second byte and the farthest node the first byte. The controller reads back the farthest node's response first, then the middle node's, then the nearest node's.
- R7: While `csn_i` is high, toggling `sclk_i` and `sdi_i` produces no strobe and changes neither `rx_data_o` nor `sdo_o`.
- R8: `sdo_o` changes only after a detected falling `sclk_i` edge or a falling `csn_i` edge.
- R9: In a frame longer than 8 bits, the node latches the last 8 bits it received. In a 16-bit frame, a single node in that position keeps the second byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk_i | input | 1 | Shared serial clock, asynchronous |
| csn_i | input | 1 | Shared active-low select, asynchronous |
| sdi_i | input | 1 | Serial input from the controller or the previous node |
| sdo_o | output | 1 | Serial output to the next node or the controller |
| resp_i | input | DATA_W | Response byte captured at the start of a frame |
| rx_data_o | output | DATA_W | Byte latched at the end of a frame |
| rx_valid_o | output | 1 | One-cycle strobe marking a new `rx_data_o` |

## Verification
The bench builds a chain of three nodes. It sweeps all 256 byte values through 8-bit frames, with every node's response derived from the swept value in a different way. A mismatch therefore shows whether data was lost in a node's own capture or in forwarding between nodes. 16-bit and 24-bit frames separate the keep-the-last-byte rule from the keep-the-first-byte rule and show the order in which responses return. A frame in which the response input changes mid-transfer, and a burst of clock toggles with the select line high, show that the response is captured only at the select edge and that the clock is ignored while the node is deselected.

// File: rtl/cnode_pkg.sv
package cnode_pkg;

  localparam int unsigned CNODE_MAX_W = 32;

  typedef logic [CNODE_MAX_W-1:0] wide_t;

  typedef struct packed {
    logic sclk;
    logic csn;
    logic sdi;
  } pins_t;

  localparam pins_t PINS_IDLE = '{sclk: 1'b0, csn: 1'b1, sdi: 1'b0};

  // Move one bit into the bottom of a w-bit register; the top bit falls off.
  function automatic wide_t shift_in(wide_t cur, logic b, int unsigned w);
    wide_t mask;
    mask = (w >= CNODE_MAX_W) ? '1 : ((wide_t'(1) << w) - wide_t'(1));
    return ((cur << 1) | wide_t'(b)) & mask;
  endfunction

  // The bit that leaves the register next: the top of a w-bit value.
  function automatic logic top_bit(wide_t cur, int unsigned w);
    return cur[w-1];
  endfunction

endpackage

// File: rtl/cnode_sync.sv
module cnode_sync
  import cnode_pkg::*;
#(
  parameter int unsigned STAGES = 2
) (
  input  logic  clk,
  input  logic  rst_n,
  input  pins_t raw_i,
  output logic  csn_s_o,
  output logic  sdi_s_o,
  output logic  sclk_rise_o,
  output logic  sclk_fall_o,
  output logic  cs_fall_o,
  output logic  cs_rise_o
);

  localparam int unsigned LAST = STAGES - 1;

  pins_t stage_q [STAGES];
  pins_t prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < STAGES; k++) stage_q[k] <= PINS_IDLE;
      prev_q <= PINS_IDLE;
    end else begin
      stage_q[0] <= raw_i;
      for (int k = 1; k < STAGES; k++) stage_q[k] <= stage_q[k-1];
      prev_q <= stage_q[LAST];
    end
  end

  assign csn_s_o     = stage_q[LAST].csn;
  assign sdi_s_o     = stage_q[LAST].sdi;
  assign sclk_rise_o =  stage_q[LAST].sclk & ~prev_q.sclk;
  assign sclk_fall_o = ~stage_q[LAST].sclk &  prev_q.sclk;
  assign cs_fall_o   = ~stage_q[LAST].csn  &  prev_q.csn;
  assign cs_rise_o   =  stage_q[LAST].csn  & ~prev_q.csn;

endmodule

// File: rtl/cnode_shifter.sv
module cnode_shifter
  import cnode_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              csn_s_i,
  input  logic              sdi_s_i,
  input  logic              sclk_rise_i,
  input  logic              sclk_fall_i,
  input  logic              cs_fall_i,
  input  logic              cs_rise_i,
  input  logic [DATA_W-1:0] resp_i,
  output logic              sdo_o,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              rx_valid_o
);

  logic [DATA_W-1:0] sh_q;
  logic              sdo_q;
  logic [DATA_W-1:0] rx_q;
  logic              vld_q;

  wide_t             shifted_w;
  logic [DATA_W-1:0] sh_next;
  logic              out_next;

  always_comb begin
    shifted_w = shift_in(wide_t'(sh_q), sdi_s_i, DATA_W);
    sh_next   = shifted_w[DATA_W-1:0];
    out_next  = top_bit(wide_t'(sh_q), DATA_W);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      sdo_q <= 1'b0;
    end else if (cs_fall_i) begin
      sh_q  <= resp_i;
      sdo_q <= top_bit(wide_t'(resp_i), DATA_W);
    end else if (!csn_s_i) begin
      if (sclk_rise_i) sh_q  <= sh_next;
      if (sclk_fall_i) sdo_q <= out_next;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_q  <= '0;
      vld_q <= 1'b0;
    end else begin
      vld_q <= cs_rise_i;
      if (cs_rise_i) rx_q <= sh_q;
    end
  end

  assign sdo_o      = sdo_q;
  assign rx_data_o  = rx_q;
  assign rx_valid_o = vld_q;

endmodule

// File: rtl/chain_spi_node.sv
module chain_spi_node
  import cnode_pkg::*;
#(
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk_i,
  input  logic              csn_i,
  input  logic              sdi_i,
  output logic              sdo_o,
  input  logic [DATA_W-1:0] resp_i,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              rx_valid_o
);

  pins_t raw_w;
  logic  csn_s_w;
  logic  sdi_s_w;
  logic  sclk_rise_w;
  logic  sclk_fall_w;
  logic  cs_fall_w;
  logic  cs_rise_w;

  assign raw_w = '{sclk: sclk_i, csn: csn_i, sdi: sdi_i};

  cnode_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .raw_i       (raw_w),
    .csn_s_o     (csn_s_w),
    .sdi_s_o     (sdi_s_w),
    .sclk_rise_o (sclk_rise_w),
    .sclk_fall_o (sclk_fall_w),
    .cs_fall_o   (cs_fall_w),
    .cs_rise_o   (cs_rise_w)
  );

  cnode_shifter #(.DATA_W(DATA_W)) shift_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .csn_s_i     (csn_s_w),
    .sdi_s_i     (sdi_s_w),
    .sclk_rise_i (sclk_rise_w),
    .sclk_fall_i (sclk_fall_w),
    .cs_fall_i   (cs_fall_w),
    .cs_rise_i   (cs_rise_w),
    .resp_i      (resp_i),
    .sdo_o       (sdo_o),
    .rx_data_o   (rx_data_o),
    .rx_valid_o  (rx_valid_o)
  );

endmodule

// File: rtl/cnode_chk.sv
module cnode_chk #(
  parameter int unsigned DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sclk_fall_w,
  input logic              cs_fall_w,
  input logic              cs_rise_w,
  input logic              sdo_o,
  input logic [DATA_W-1:0] resp_i,
  input logic [DATA_W-1:0] rx_data_o,
  input logic              rx_valid_o
);

  // R3
  strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid_o |=> !rx_valid_o);

  // R3
  strobe_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid_o |-> $past(cs_rise_w));

  // R3
  rx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_valid_o |-> $stable(rx_data_o));

  // R4
  preload_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_fall_w |=> (sdo_o == $past(resp_i[DATA_W-1])));

  // R8
  sdo_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sdo_o) |-> $past(sclk_fall_w || cs_fall_w));

endmodule

bind chain_spi_node cnode_chk #(.DATA_W(DATA_W)) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .sclk_fall_w (sclk_fall_w),
  .cs_fall_w   (cs_fall_w),
  .cs_rise_w   (cs_rise_w),
  .sdo_o       (sdo_o),
  .resp_i      (resp_i),
  .rx_data_o   (rx_data_o),
  .rx_valid_o  (rx_valid_o)
);

// File: tb/chain_spi_node_tb_top.sv
`timescale 1ns/1ps
module chain_spi_node_tb_top;

  localparam int HALF = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk = 1'b0;
  logic csn = 1'b1;
  logic sdi = 1'b0;
  logic [7:0] resp1 = '0, resp2 = '0, resp3 = '0;
  logic sdo1, sdo2, sdo3;
  logic [7:0] rx1, rx2, rx3;
  logic vld1, vld2, vld3;

  int checks = 0;
  int fails = 0;
  int c1 = 0, c2 = 0, c3 = 0;
  logic [31:0] got1, got3;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  chain_spi_node dut_i (
    .clk(clk), .rst_n(rst_n), .sclk_i(sclk), .csn_i(csn), .sdi_i(sdi),
    .sdo_o(sdo1), .resp_i(resp1), .rx_data_o(rx1), .rx_valid_o(vld1));
  chain_spi_node node_b (
    .clk(clk), .rst_n(rst_n), .sclk_i(sclk), .csn_i(csn), .sdi_i(sdo1),
    .sdo_o(sdo2), .resp_i(resp2), .rx_data_o(rx2), .rx_valid_o(vld2));
  chain_spi_node node_c (
    .clk(clk), .rst_n(rst_n), .sclk_i(sclk), .csn_i(csn), .sdi_i(sdo2),
    .sdo_o(sdo3), .resp_i(resp3), .rx_data_o(rx3), .rx_valid_o(vld3));

  always @(posedge clk) begin
    if (vld1) c1++;
    if (vld2) c2++;
    if (vld3) c3++;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  // One select-low frame of nbits, first bit = data[nbits-1].
  task automatic run_frame(input int nbits, input logic [31:0] data, input bit poke);
    c1 = 0; c2 = 0; c3 = 0;
    got1 = '0; got3 = '0;
    @(negedge clk);
    csn = 1'b0;
    wait_n(HALF);
    if (poke) resp1 = ~resp1;
    for (int i = 0; i < nbits; i++) begin
      sdi = data[nbits-1-i];
      wait_n(HALF);
      got1 = {got1[30:0], sdo1};
      got3 = {got3[30:0], sdo3};
      sclk = 1'b1;
      wait_n(HALF);
      sclk = 1'b0;
    end
    wait_n(HALF);
    csn = 1'b1;
    wait_n(12);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] r1, b0, b1, b2, keep_rx;
    logic keep_sdo;
    wait_n(5);
    rst_n = 1'b1;
    wait_n(2);
    // R1
    chk("R1 sdo", 32'(sdo1), 32'd0);
    chk("R1 rx", 32'(rx1), 32'd0);
    chk("R1 valid", 32'(vld1), 32'd0);

    // Sweep every byte through an 8-bit frame.
    for (int v = 0; v < 256; v++) begin
      resp1 = 8'(v) ^ 8'hA5;
      resp2 = 8'(v) + 8'h3C;
      resp3 = {8'(v) & 8'h0F, 8'(v) >> 4} [7:0];
      resp3 = {resp3[3:0], 4'(v >> 4)};
      run_frame(8, 32'(v), 1'b0);
      chk("R2 node1 byte", 32'(rx1), 32'(v));
      chk("R4 node1 response out", got1 & 32'hFF, 32'(resp1));
      chk("R6 node2 gets node1 response", 32'(rx2), 32'(resp1));
      chk("R6 node3 gets node2 response", 32'(rx3), 32'(resp2));
      chk("R6 controller reads node3", got3 & 32'hFF, 32'(resp3));
      chk("R3 strobe count", 32'(c1 + c2 + c3), 32'd3);
    end

    // R9: 16-bit frame, node1 keeps the second byte.
    resp1 = 8'h5A; resp2 = 8'hC3; resp3 = 8'h81;
    run_frame(16, 32'h0000_E71B, 1'b0);
    chk("R9 node1 keeps last byte", 32'(rx1), 32'h1B);
    chk("R9 node2 gets first byte", 32'(rx2), 32'hE7);
    chk("R9 node3 gets node1 response", 32'(rx3), 32'h5A);
    chk("R5 node1 forwards input", got1 & 32'hFFFF, 32'h5AE7);

    // R6 / R4: 24-bit frame with the response input poked mid-frame.
    for (int t = 0; t < 4; t++) begin
      b0 = 8'(8'h11 * (t + 3)); b1 = 8'(8'h2D ^ (t * 8'h47)); b2 = 8'(8'hF0 - t * 8'h19);
      r1 = 8'(8'h96 + t); resp1 = r1; resp2 = 8'(8'h3E ^ t); resp3 = 8'(8'hC1 + t * 3);
      run_frame(24, {8'h00, b0, b1, b2}, 1'b1);
      chk("R6 node3 first byte", 32'(rx3), 32'(b0));
      chk("R6 node2 second byte", 32'(rx2), 32'(b1));
      chk("R6 node1 third byte", 32'(rx1), 32'(b2));
      chk("R6 R4 readback order", got3 & 32'hFF_FFFF, {8'h00, resp3, resp2, r1});
      chk("R5 node1 delayed stream", got1 & 32'hFF_FFFF, {8'h00, r1, b0, b1});
    end

    // R7: clock and data toggles while deselected.
    keep_rx = rx1; keep_sdo = sdo1;
    c1 = 0;
    for (int i = 0; i < 10; i++) begin
      sdi = i[0]; sclk = 1'b1; wait_n(HALF); sclk = 1'b0; wait_n(HALF);
    end
    wait_n(8);
    chk("R7 no strobe", 32'(c1), 32'd0);
    chk("R7 rx held", 32'(rx1), 32'(keep_rx));
    chk("R7 sdo held", 32'(sdo1), 32'(keep_sdo));

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule